// File: doc/BRIEF.md
# Pipelined SPI ADC scan sequencer

This block is an SPI master for a multi-channel successive-approximation converter whose replies lag its commands by two frames. On a trigger it walks a channel enable mask from the lowest index upward, sends one 16-bit command per enabled channel, then sends two flush frames so that the last replies come back. Each reply is matched against the channel it should belong to. The sample is cut out at the configured resolution and handed to a valid/ready stream together with the channel number and a mismatch flag.

A direct mode reads one chosen channel with three frames. An input bit selects the doubled input range in every command. The serial clock comes from a divider of the system clock (mode 0: idle low, data launched on the falling edge, sampled on the rising edge). Chip select is held high for a configurable minimum time between frames. A full result that the consumer has not yet taken holds the next frame back.

Top module: `adc_scan_seq`

## Requirements
- R1: Each frame is 16 serial clocks, most significant bit first, in mode 0. The serial clock is low whenever chip select is high. Chip select stays high for at least CS_GAP system cycles between frames, and it stays high after the last frame of a sequence.
- R2: A command word has bits 15:13 = 0, bit 12 = 1 (manual channel select), bit 11 = 1 (settings update), the channel in bits 10:7, the range bit in bit 6, and bits 5:0 = 0.
- R3: A scan of N enabled channels sends exactly N+2 frames. The first N carry the commands for the enabled channels in ascending index order. The last two repeat the final command word.
- R4: Each enabled channel yields exactly one result, in ascending channel order. The reply is taken from the frame two positions after the channel's command. The result data is reply bits 11 down to 12-RES_BITS.
- R5: When reply bits 15:12 differ from the channel the reply belongs to, res_err_o is 1 for that result and the data is still delivered. Otherwise res_err_o is 0.
- R6: In direct mode (direct_i = 1) a trigger reads only channel direct_ch_i, ignoring ch_mask_i. This takes three frames that all carry that channel's command, and produces one result.
- R7: busy_o rises only on an accepted trigger and stays high until the last result of the sequence is accepted. A trigger while busy_o is high is ignored. Mask, mode and range are latched when the trigger is accepted.
- R8: While res_valid_o is high and res_ready_i is low, the channel, data and error outputs hold steady, and no new frame begins.
- R9: After reset, chip select is high, the serial clock is low, and res_valid_o and busy_o are low.
- R10: A trigger in scan mode with an all-zero mask is ignored. No frame is sent and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start a sequence (one-cycle pulse) |
| direct_i | input | 1 | 1: single-channel direct read, 0: mask scan |
| direct_ch_i | input | CH_W | Channel for direct read |
| ch_mask_i | input | NUM_CH | Channel enable mask for scans |
| range_hi_i | input | 1 | Doubled input range bit placed in commands |
| busy_o | output | 1 | Sequence in progress |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Serial data from converter |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted |
| res_ch_o | output | CH_W | Channel of the result |
| res_data_o | output | RES_BITS | Right-aligned sample |
| res_err_o | output | 1 | Reply tag did not match the channel |

## Verification
The bench drives a converter model that answers each frame with the channel and sample of the command sent two frames earlier. Scans are run with a full mask, with single low and single high channels, and with random sparse masks. These separate the ascending walk, the flush count and the two-frame alignment: any misalignment returns neighbouring channels' samples. Direct reads at channels 5 and 15, with a contradicting mask applied, show that the mask is ignored. A model that corrupts the tag of one chosen channel shows that the error lands on that result only. A retrigger with a different mask mid-scan, and an empty-mask trigger, show the ignore rules. A random ready signal exercises the hold and stall behaviour on every run.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W = 16;
  localparam int TAG_W   = 4;
  localparam int DATA_MSB = 11;

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} frame_st_e;
  typedef enum logic {C_IDLE, C_RUN} ctrl_st_e;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] ch;
  } tag_t;

  function automatic logic [FRAME_W-1:0] build_cmd(logic [TAG_W-1:0] ch, logic rng);
    build_cmd = {3'b000, 1'b1, 1'b1, ch, rng, 6'b000000};
  endfunction
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               idle_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  frame_st_e          st_q;
  logic [DIV_W-1:0]   div_q;
  logic [GAP_W-1:0]   gap_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_q, rx_q;

  assign idle_o    = (st_q == F_IDLE);
  assign mosi_o    = tx_q[FRAME_W-1];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      div_q  <= '0;
      gap_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_o <= 1'b0;
      cs_no  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        F_IDLE: if (start_i) begin
          tx_q  <= tx_word_i;
          cs_no <= 1'b0;
          div_q <= '0;
          bit_q <= '0;
          st_q  <= F_SHIFT;
        end
        F_SHIFT: begin
          if (div_q == DIV_W'(CLK_DIV - 1)) begin
            div_q <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
              rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
            end else begin
              sclk_o <= 1'b0;
              tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
              if (bit_q == BIT_W'(FRAME_W - 1)) begin
                cs_no <= 1'b1;
                gap_q <= '0;
                st_q  <= F_GAP;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        F_GAP: begin
          if (gap_q == GAP_W'(CS_GAP - 1)) begin
            st_q   <= F_IDLE;
            done_o <= 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               direct_i,
  input  logic [CH_W-1:0]    direct_ch_i,
  input  logic [NUM_CH-1:0]  ch_mask_i,
  input  logic               range_hi_i,
  input  logic               eng_idle_i,
  input  logic               eng_done_i,
  input  logic               hold_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] tx_word_o,
  output logic               cap_o,
  output logic [TAG_W-1:0]   cap_ch_o,
  output logic               busy_o
);
  ctrl_st_e           st_q;
  logic [NUM_CH-1:0]  pend_q, pend_load;
  logic [1:0]         flush_q;
  logic               inflight_q, range_q;
  logic [FRAME_W-1:0] cmd_q, next_cmd;
  tag_t [2:0]         tag_q;
  logic [CH_W-1:0]    sel;
  logic               sel_vld, dch_ok, accept, free;

  generate
    if (NUM_CH == (1 << CH_W)) begin : g_full_span
      assign dch_ok = 1'b1;
    end else begin : g_part_span
      assign dch_ok = ({1'b0, direct_ch_i} < (CH_W+1)'(NUM_CH));
    end
  endgenerate

  assign pend_load = direct_i ? (dch_ok ? (NUM_CH'(1) << direct_ch_i) : '0) : ch_mask_i;
  assign accept    = (st_q == C_IDLE) && trig_i && (|pend_load);

  // lowest pending channel goes first
  always_comb begin
    sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = CH_W'(i);
    end
  end
  assign sel_vld  = |pend_q;
  assign next_cmd = build_cmd(TAG_W'(sel), range_q);

  assign free      = (st_q == C_RUN) && !inflight_q && eng_idle_i && !hold_i;
  assign start_o   = free && (sel_vld || (flush_q != 2'd0));
  assign tx_word_o = sel_vld ? next_cmd : cmd_q;
  assign cap_o     = eng_done_i && tag_q[2].vld;
  assign cap_ch_o  = tag_q[2].ch;
  assign busy_o    = (st_q == C_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= C_IDLE;
      pend_q     <= '0;
      flush_q    <= '0;
      inflight_q <= 1'b0;
      range_q    <= 1'b0;
      cmd_q      <= '0;
      tag_q      <= '0;
    end else begin
      if (accept) begin
        st_q    <= C_RUN;
        pend_q  <= pend_load;
        flush_q <= 2'd2;
        range_q <= range_hi_i;
        tag_q   <= '0;
      end else if (start_o) begin
        inflight_q <= 1'b1;
        tag_q[2]   <= tag_q[1];
        tag_q[1]   <= tag_q[0];
        if (sel_vld) begin
          pend_q[sel] <= 1'b0;
          cmd_q       <= next_cmd;
          tag_q[0]    <= '{vld: 1'b1, ch: TAG_W'(sel)};
        end else begin
          flush_q  <= flush_q - 2'd1;
          tag_q[0] <= '0;
        end
      end else if (free) begin
        st_q <= C_IDLE;
      end
      if (eng_done_i) inflight_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_resp_unpack.sv
module adc_resp_unpack
  import adc_scan_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CH_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [TAG_W-1:0]    cap_ch_i,
  input  logic [FRAME_W-1:0]  rx_word_i,
  input  logic                res_ready_i,
  output logic                res_valid_o,
  output logic [CH_W-1:0]     res_ch_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic                res_err_o
);
  localparam int LSB = DATA_MSB + 1 - RES_BITS;

  generate
    if (LSB > 0) begin : g_drop_lsb
      logic unused_lsb;
      assign unused_lsb = ^rx_word_i[LSB-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_ch_o    <= '0;
      res_data_o  <= '0;
      res_err_o   <= 1'b0;
    end else if (cap_i) begin
      res_valid_o <= 1'b1;
      res_ch_o    <= cap_ch_i[CH_W-1:0];
      res_data_o  <= rx_word_i[DATA_MSB:LSB];
      res_err_o   <= (rx_word_i[FRAME_W-1 -: TAG_W] != cap_ch_i);
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int CLK_DIV  = 2,
  parameter int CS_GAP   = 2,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trig_i,
  input  logic                direct_i,
  input  logic [CH_W-1:0]     direct_ch_i,
  input  logic [NUM_CH-1:0]   ch_mask_i,
  input  logic                range_hi_i,
  output logic                busy_o,
  output logic                sclk_o,
  output logic                cs_no,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [CH_W-1:0]     res_ch_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic                res_err_o
);
  logic               start, eng_idle, eng_done, cap;
  logic [FRAME_W-1:0] tx_word, rx_word;
  logic [TAG_W-1:0]   cap_ch;

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
    .clk_i, .rst_ni, .trig_i, .direct_i, .direct_ch_i, .ch_mask_i, .range_hi_i,
    .eng_idle_i (eng_idle),
    .eng_done_i (eng_done),
    .hold_i     (res_valid_o),
    .start_o    (start),
    .tx_word_o  (tx_word),
    .cap_o      (cap),
    .cap_ch_o   (cap_ch),
    .busy_o
  );

  adc_spi_frame #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) i_frame (
    .clk_i, .rst_ni,
    .start_i   (start),
    .tx_word_i (tx_word),
    .idle_o    (eng_idle),
    .done_o    (eng_done),
    .rx_word_o (rx_word),
    .sclk_o, .cs_no, .mosi_o, .miso_i
  );

  adc_resp_unpack #(.RES_BITS(RES_BITS), .CH_W(CH_W)) i_unpack (
    .clk_i, .rst_ni,
    .cap_i     (cap),
    .cap_ch_i  (cap_ch),
    .rx_word_i (rx_word),
    .res_ready_i, .res_valid_o, .res_ch_o, .res_data_o, .res_err_o
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int RES_BITS = 12,
  parameter int CH_W     = 4,
  parameter int CS_GAP   = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                trig_i,
  input logic                busy_o,
  input logic                sclk_o,
  input logic                cs_no,
  input logic                res_valid_o,
  input logic                res_ready_i,
  input logic [CH_W-1:0]     res_ch_o,
  input logic [RES_BITS-1:0] res_data_o,
  input logic                res_err_o
);
  logic [15:0] high_cnt_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_cnt_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      if (cs_no) high_cnt_q <= (high_cnt_q == 16'hFFFF) ? high_cnt_q : high_cnt_q + 1'b1;
      else begin
        high_cnt_q <= '0;
        seen_q     <= 1'b1;
      end
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R1
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_q) |-> (high_cnt_q >= 16'(CS_GAP)));

  // R9
  cs_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(trig_i));

  // R8
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_data_o) && $stable(res_ch_o) && $stable(res_err_o)));

  // R8
  stall_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && res_valid_o) |=> cs_no);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.RES_BITS(RES_BITS), .CH_W(CH_W), .CS_GAP(CS_GAP)) i_scan_chk (
  .clk_i, .rst_ni, .trig_i, .busy_o, .sclk_o, .cs_no,
  .res_valid_o, .res_ready_i, .res_ch_o, .res_data_o, .res_err_o
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NUM_CH = 16;
  localparam int RES    = 10;
  localparam int DIV    = 2;
  localparam int GAP    = 3;
  localparam int CH_W   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni, trig_i, direct_i, range_hi_i, miso_i, res_ready_i;
  logic [CH_W-1:0]   direct_ch_i;
  logic [NUM_CH-1:0] ch_mask_i;
  logic              busy_o, sclk_o, cs_no, mosi_o, res_valid_o, res_err_o;
  logic [CH_W-1:0]   res_ch_o;
  logic [RES-1:0]    res_data_o;

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_BITS(RES), .CLK_DIV(DIV), .CS_GAP(GAP)) i_adc_scan_seq (
    .clk_i(clk), .rst_ni, .trig_i, .direct_i, .direct_ch_i, .ch_mask_i, .range_hi_i,
    .busy_o, .sclk_o, .cs_no, .mosi_o, .miso_i,
    .res_valid_o, .res_ready_i, .res_ch_o, .res_data_o, .res_err_o
  );

  int checks = 0, errors = 0;
  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmd(int ch, bit rng);
    logic [3:0] c = 4'(ch);
    return {3'b000, 1'b1, 1'b1, c, rng, 6'b0};
  endfunction

  // converter model: reply carries channel and sample of the command two frames back
  logic [11:0] val [NUM_CH];
  int          bad_ch = 99;
  logic [15:0] mon_sr, miso_sr;
  logic [15:0] mon_cmd [64];
  int          mon_bits = 0, mon_n = 0, bad_len = 0, frames_total = 0;
  logic [3:0]  ch_a = '0, ch_b = '0, tag_m;

  always @(negedge cs_no) begin
    mon_bits = 0;
    tag_m    = (int'(ch_b) == bad_ch) ? (ch_b ^ 4'h1) : ch_b;
    miso_sr  = {tag_m, val[ch_b]};
    miso_i   = miso_sr[15];
  end
  always @(negedge sclk_o) if (!cs_no) begin
    miso_sr = {miso_sr[14:0], 1'b0};
    miso_i  = miso_sr[15];
  end
  always @(posedge sclk_o) if (!cs_no) begin
    mon_sr   = {mon_sr[14:0], mosi_o};
    mon_bits = mon_bits + 1;
  end
  always @(posedge cs_no) if (rst_ni) begin
    if (mon_bits != 16) bad_len++;
    if (mon_n < 64) mon_cmd[mon_n] = mon_sr;
    mon_n++;
    frames_total++;
    ch_b = ch_a;
    ch_a = mon_sr[10:7];
  end

  // result sink with random ready, hold and gap observers
  int          got_n = 0;
  logic [3:0]  got_ch [32];
  logic [RES-1:0] got_data [32];
  logic        got_err [32];
  bit          hold_pend = 0, prev_cs = 1, prev_stall = 0;
  logic [RES+CH_W:0] hold_snap;
  int          stall_seen = 0, stall_viol = 0, gap_run = 0, min_gap = 1000;
  bit          rdy;

  always @(negedge clk) begin
    if (rst_ni) begin
      rdy = ($urandom % 3) != 0;
      if (hold_pend) begin
        stall_seen++;
        if (!res_valid_o || hold_snap != {res_err_o, res_ch_o, res_data_o}) stall_viol++;
      end
      if (prev_stall && prev_cs && !cs_no) stall_viol++;
      hold_pend  = res_valid_o && !rdy;
      hold_snap  = {res_err_o, res_ch_o, res_data_o};
      res_ready_i = rdy;
      if (res_valid_o && rdy && got_n < 32) begin
        got_ch[got_n]   = 4'(res_ch_o);
        got_data[got_n] = res_data_o;
        got_err[got_n]  = res_err_o;
        got_n++;
      end
      if (cs_no) gap_run++;
      else begin
        if (prev_cs && frames_total > 0 && gap_run < min_gap) min_gap = gap_run;
        gap_run = 0;
      end
      prev_stall = res_valid_o;
      prev_cs    = cs_no;
    end
  end

  task automatic run_scan(logic [15:0] mask, bit dir, int dch, bit rng, int bad, bit retrig);
    int lst[16];
    int n = 0;
    bit ok;
    int first_bad;
    for (int c = 0; c < NUM_CH; c++) val[c] = 12'($urandom);
    bad_ch = bad;
    @(negedge clk);
    mon_n = 0; got_n = 0;
    ch_mask_i = mask; direct_i = dir; direct_ch_i = 4'(dch); range_hi_i = rng; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    if (retrig) begin
      repeat (200) @(negedge clk);
      check(busy_o == 1'b1, "R7", "busy during scan", int'(busy_o), 1);
      ch_mask_i = ~mask; range_hi_i = ~rng; direct_i = 1'b0; trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (6) @(negedge clk);
    if (dir) begin lst[0] = dch; n = 1; end
    else for (int c = 0; c < NUM_CH; c++) if (mask[c]) begin lst[n] = c; n++; end
    check(mon_n == n + 2, dir ? "R6" : "R3", "frame count", mon_n, n + 2);
    ok = 1; first_bad = 0;
    for (int i = 0; i < n + 2 && i < mon_n; i++) begin
      if (mon_cmd[i] != exp_cmd(lst[(i < n) ? i : n - 1], rng) && ok) begin
        ok = 0; first_bad = i;
      end
    end
    check(ok, "R2", "command words", int'(mon_cmd[first_bad]),
          int'(exp_cmd(lst[(first_bad < n) ? first_bad : n - 1], rng)));
    check(got_n == n, "R4", "result count", got_n, n);
    ok = 1; first_bad = 0;
    for (int i = 0; i < n && i < got_n; i++) begin
      if ((got_ch[i] != 4'(lst[i]) || got_data[i] != RES'(val[lst[i]] >> (12 - RES))) && ok) begin
        ok = 0; first_bad = i;
      end
    end
    check(ok, "R4", "result channel/data", int'({got_ch[first_bad], got_data[first_bad]}),
          int'({4'(lst[first_bad]), RES'(val[lst[first_bad]] >> (12 - RES))}));
    ok = 1; first_bad = 0;
    for (int i = 0; i < n && i < got_n; i++) begin
      if (got_err[i] != (lst[i] == bad) && ok) begin ok = 0; first_bad = i; end
    end
    check(ok, "R5", "error flag", int'(got_err[first_bad]), int'(lst[first_bad] == bad));
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; trig_i = 1'b0; direct_i = 1'b0; direct_ch_i = '0;
    ch_mask_i = '0; range_hi_i = 1'b0; res_ready_i = 1'b0; miso_i = 1'b0;
    for (int c = 0; c < NUM_CH; c++) val[c] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cs_no && !sclk_o && !res_valid_o && !busy_o, "R9", "reset state",
          int'({cs_no, sclk_o, res_valid_o, busy_o}), 4'b1000);

    run_scan(16'hFFFF, 0, 0, 1, 99, 0);
    run_scan(16'h0001, 0, 0, 0, 99, 0);
    run_scan(16'h8000, 0, 0, 1, 99, 0);
    run_scan(16'h0A50, 1, 5, 0, 99, 0);   // R6 mask ignored
    run_scan(16'h0001, 1, 15, 1, 99, 0);  // R6 top channel
    run_scan(16'h0F0F, 0, 0, 0, 8, 0);    // R5 one bad tag
    run_scan(16'h00F0, 0, 0, 1, 99, 1);   // R7 retrigger ignored

    // R10 empty mask
    @(negedge clk);
    mon_n = 0;
    ch_mask_i = '0; direct_i = 1'b0; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    repeat (100) @(negedge clk);
    check(!busy_o && mon_n == 0, "R10", "empty mask idle", int'({busy_o, 8'(mon_n)}), 0);

    for (int k = 0; k < 16; k++) begin
      logic [15:0] m = 16'($urandom);
      if (m == 0) m = 16'h0100;
      run_scan(m, ($urandom % 5) == 0, int'($urandom % 16), 1'($urandom),
               (($urandom % 4) == 0) ? int'($urandom % 16) : 99, 0);
    end

    check(bad_len == 0, "R1", "16-bit frames", bad_len, 0);
    check(min_gap >= GAP, "R1", "chip select gap", min_gap, GAP);
    check(stall_viol == 0 && stall_seen > 0, "R8", "hold under backpressure", stall_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R3: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule